// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer. A prescaler divides the watchdog clock and drives a 12-bit down-counter. When the counter runs out, the block raises a one-cycle reset request. Software reaches the block through four 32-bit word registers: key (0x0), divider code (0x4), timeout value (0x8) and update flags (0xC). Only three full 32-bit key words do anything special. `0x00005555` opens the divider and timeout registers for writing. `0x0000CCCC` starts the watchdog. `0x0000AAAA` refreshes the counter. Once the watchdog is running, nothing except the block's reset can stop it.

Writes to the divider and timeout registers land in a visible copy at once. The copy in force is updated a fixed number of cycles later, which stands in for the crossing into the slow clock domain. An update flag is set while that update is pending, and a second write to the same register is ignored until the flag clears. A timeout value of N gives a timeout of N+1 prescaled ticks.

The control is built from three state machines:
- **Lock machine**: states LK_LOCKED and LK_OPEN. A key write of `0x00005555` moves it to LK_OPEN. Any other key write moves it to LK_LOCKED.
- **Shadow machine** (one per configuration register): states SH_IDLE and SH_BUSY. An accepted write moves it from SH_IDLE to SH_BUSY. When the latency count ends it returns to SH_IDLE and copies the written value into the copy in force.
- **Watchdog machine**: states WD_STOPPED, WD_RUNNING and WD_EXPIRED.
  - WD_STOPPED goes to WD_RUNNING on a start key.
  - WD_RUNNING goes to WD_EXPIRED on a tick while the count is zero.
  - WD_EXPIRED always goes back to WD_RUNNING on the next cycle.
  - A start or refresh key reloads the count from the timeout value in force.

Top module: `keywdt_top`

## Requirements
- R1: After reset, the divider code reads 0, the timeout value reads 0xFFF, the update flags read 0 and the reset request is low.
- R2: After a key write of 0x00005555, a write to the divider register (bits 2:0) or to the timeout register (bits 11:0) is accepted. The new value reads back from the next cycle.
- R3: A key write of any value other than 0x00005555 locks the divider and timeout registers again. Writes to them while locked leave their read-back unchanged.
- R4: An accepted divider write sets status bit 0, and an accepted timeout write sets status bit 1. Each flag is set for exactly LAT cycles after the write edge (LAT is 5 by default) and then reads 0.
- R5: A write to the divider or timeout register while its own flag is set is ignored.
- R6: Divider code c gives a tick every 4·2^c watchdog-clock cycles for c from 0 to 6. Code 7 behaves like code 6 (a tick every 256 cycles).
- R7: The reset request stays low until a key write of 0x0000CCCC. After that write, with code c and timeout value N in force, the request goes high for exactly one cycle, (N+1)·4·2^c cycles after the write edge.
- R8: A key write of 0x0000AAAA while running restarts the count and the prescaler phase. The next reset request then comes (N+1)·4·2^c cycles after that write edge.
- R9: Once started, the watchdog keeps running. No key or register write stops it. Reset requests repeat with period (N+1)·4·2^c, so any window of that many cycles holds exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; it also serves as the register-write clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one register write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wd_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
- **Register read-back and update flags**: a new register value reads back on the cycle after its write edge. An update flag is high from that cycle through LAT cycles and reads low after the LAT-th edge. The bench samples the flag at the last cycle it should be high and at the first cycle it should be low.
- **Reset request timing**: the request appears in the cycle after edge (N+1)·4·2^c, counted from the start or refresh write edge. The bench counts falling edges from that write and requires the first high sample at exactly that count, with only one high sample in the window.
- **Random configurations**: these are re-timed from a refresh, issued after the flags have cleared, so the values in force are known.

// File: rtl/keywdt_pkg.sv
package keywdt_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_KEY = 4'h0;
    localparam logic [ADDR_W-1:0] A_DIV = 4'h4;
    localparam logic [ADDR_W-1:0] A_TMO = 4'h8;
    localparam logic [ADDR_W-1:0] A_FLG = 4'hC;

    localparam logic [31:0] KEY_OPEN    = 32'h0000_5555;
    localparam logic [31:0] KEY_START   = 32'h0000_CCCC;
    localparam logic [31:0] KEY_REFRESH = 32'h0000_AAAA;

    typedef enum logic [1:0] {
        WD_STOPPED = 2'd0,
        WD_RUNNING = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } shadow_state_e;
endpackage

// File: rtl/keywdt_shadow_reg.sv
module keywdt_shadow_reg
    import keywdt_pkg::*;
#(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          LAT     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] val_q,
    output logic [W-1:0] act_q,
    output logic         busy_o
);
    localparam int LW = $clog2(LAT + 1);
    localparam logic [LW-1:0] LAT_V = LW'(LAT);

    shadow_state_e state_q, state_n;
    logic [LW-1:0] lat_q, lat_n;
    logic [W-1:0]  val_n, act_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            lat_q   <= '0;
            val_q   <= RST_VAL;
            act_q   <= RST_VAL;
        end else begin
            state_q <= state_n;
            lat_q   <= lat_n;
            val_q   <= val_n;
            act_q   <= act_n;
        end
    end

    always_comb begin
        state_n = state_q;
        lat_n   = lat_q;
        val_n   = val_q;
        act_n   = act_q;
        unique case (state_q)
            SH_IDLE: begin
                if (wr_req) begin
                    state_n = SH_BUSY;
                    lat_n   = LAT_V;
                    val_n   = wr_data;
                end
            end
            SH_BUSY: begin
                if (lat_q <= LW'(1)) begin
                    state_n = SH_IDLE;
                    lat_n   = '0;
                    act_n   = val_q;
                end else begin
                    lat_n = lat_q - LW'(1);
                end
            end
            default: state_n = SH_IDLE;
        endcase
    end

    always_comb busy_o = (state_q == SH_BUSY);
endmodule

// File: rtl/keywdt_prescaler.sv
module keywdt_prescaler #(
    parameter int PRE_W    = 3,
    parameter int MAX_CODE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PRE_W-1:0] code_i,
    output logic             tick_o
);
    localparam int DIV_W = MAX_CODE + 2;

    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] eff;
    logic [DIV_W:0]   lim;
    logic             at_lim;

    always_comb begin
        eff    = (int'(code_i) > MAX_CODE) ? PRE_W'(MAX_CODE) : code_i;
        lim    = ((DIV_W + 1)'(1) << (int'(eff) + 2)) - (DIV_W + 1)'(1);
        at_lim = ({1'b0, div_q} >= lim);
        tick_o = run_i && !restart_i && at_lim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run_i || restart_i || at_lim)
            div_q <= '0;
        else
            div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/keywdt_counter.sv
module keywdt_counter
    import keywdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             refresh_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             run_o,
    output logic             expire_o
);
    wd_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_STOPPED;
            cnt_q   <= '1;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            WD_STOPPED: begin
                if (start_i) begin
                    state_n = WD_RUNNING;
                    cnt_n   = reload_i;
                end
            end
            WD_RUNNING, WD_EXPIRED: begin
                state_n = WD_RUNNING;
                if (start_i || refresh_i) begin
                    cnt_n = reload_i;
                end else if (tick_i) begin
                    if (cnt_q == '0) begin
                        state_n = WD_EXPIRED;
                        cnt_n   = reload_i;
                    end else begin
                        cnt_n = cnt_q - CNT_W'(1);
                    end
                end
            end
            default: state_n = WD_STOPPED;
        endcase
    end

    always_comb begin
        run_o    = (state_q != WD_STOPPED);
        expire_o = (state_q == WD_EXPIRED);
    end
endmodule

// File: rtl/keywdt_top.sv
module keywdt_top
    import keywdt_pkg::*;
#(
    parameter int PRE_W    = 3,
    parameter int MAX_CODE = 6,
    parameter int CNT_W    = 12,
    parameter int LAT      = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wd_rst_o
);
    lock_state_e      lock_q, lock_n;
    logic             key_wr, start_p, refresh_p, unlocked_w;
    logic             div_wr, tmo_wr;
    logic [PRE_W-1:0] div_q, div_act;
    logic [CNT_W-1:0] tmo_q, tmo_act;
    logic             div_busy, tmo_busy;
    logic             tick_w, run_w, expire_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= LK_LOCKED;
        else        lock_q <= lock_n;
    end

    always_comb begin
        key_wr = bus_wr && (bus_addr == A_KEY);
        lock_n = lock_q;
        unique case (lock_q)
            LK_LOCKED: if (key_wr && bus_wdata == KEY_OPEN)  lock_n = LK_OPEN;
            LK_OPEN:   if (key_wr && bus_wdata != KEY_OPEN)  lock_n = LK_LOCKED;
            default:   lock_n = LK_LOCKED;
        endcase
    end

    always_comb begin
        unlocked_w = (lock_q == LK_OPEN);
        start_p    = key_wr && (bus_wdata == KEY_START);
        refresh_p  = key_wr && (bus_wdata == KEY_REFRESH);
        div_wr     = bus_wr && (bus_addr == A_DIV) && unlocked_w && !div_busy;
        tmo_wr     = bus_wr && (bus_addr == A_TMO) && unlocked_w && !tmo_busy;
    end

    keywdt_shadow_reg #(.W(PRE_W), .RST_VAL('0), .LAT(LAT)) u_div (
        .clk(clk), .rst_n(rst_n), .wr_req(div_wr), .wr_data(bus_wdata[PRE_W-1:0]),
        .val_q(div_q), .act_q(div_act), .busy_o(div_busy)
    );

    keywdt_shadow_reg #(.W(CNT_W), .RST_VAL('1), .LAT(LAT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .wr_req(tmo_wr), .wr_data(bus_wdata[CNT_W-1:0]),
        .val_q(tmo_q), .act_q(tmo_act), .busy_o(tmo_busy)
    );

    keywdt_prescaler #(.PRE_W(PRE_W), .MAX_CODE(MAX_CODE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .restart_i(start_p || refresh_p),
        .code_i(div_act), .tick_o(tick_w)
    );

    keywdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_i(start_p), .refresh_i(refresh_p),
        .tick_i(tick_w), .reload_i(tmo_act), .run_o(run_w), .expire_o(expire_w)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_DIV:   bus_rdata = 32'(div_q);
            A_TMO:   bus_rdata = 32'(tmo_q);
            A_FLG:   bus_rdata = {30'd0, tmo_busy, div_busy};
            default: bus_rdata = '0;
        endcase
        wd_rst_o = expire_w;
    end
endmodule

// File: rtl/keywdt_checker.sv
module keywdt_checker
    import keywdt_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic             wd_rst_o,
    input logic             unlocked,
    input logic             running,
    input logic             div_busy,
    input logic             tmo_busy,
    input logic [PRE_W-1:0] div_q,
    input logic [CNT_W-1:0] tmo_q
);
    assert_locked_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIV && !unlocked) |=> $stable(div_q));

    assert_locked_tmo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TMO && !unlocked) |=> $stable(tmo_q));

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIV && unlocked && !div_busy) |=> div_busy);

    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TMO && tmo_busy) |=> $stable(tmo_q));

    assert_quiet_before_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !wd_rst_o);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_o |=> !wd_rst_o);

    assert_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);
endmodule

bind keywdt_top keywdt_checker #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wd_rst_o(wd_rst_o), .unlocked(unlocked_w), .running(run_w),
    .div_busy(div_busy), .tmo_busy(tmo_busy), .div_q(div_q), .tmo_q(tmo_q)
);

// File: tb/keywdt_top_tb.sv
module keywdt_top_tb;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_rst_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    keywdt_top #(.LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst_o(wd_rst_o)
    );

    function automatic int exp_period(input int code, input int n);
        int c;
        c = (code > 6) ? 6 : code;
        return (n + 1) * (4 << c);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int exp, input string req);
        int first = -1;
        int highs = 0;
        for (int i = 1; i <= exp + 2; i++) begin
            @(negedge clk);
            if (wd_rst_o) begin
                highs++;
                if (first < 0) first = i;
            end
        end
        check(first == exp, req, first, exp);
        check(highs == 1, req, highs, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int highs;
        void'($urandom(32'd77));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h4, rd); check(rd == 0, "R1 div", rd, 0);
        bus_read(4'h8, rd); check(rd == 32'hFFF, "R1 tmo", rd, 32'hFFF);
        bus_read(4'hC, rd); check(rd == 0, "R1 flags", rd, 0);
        check(wd_rst_o == 1'b0, "R1 rst", wd_rst_o, 0);

        // R3 locked writes ignored
        bus_write(4'h4, 32'd3);
        bus_read(4'h4, rd); check(rd == 0, "R3 locked div", rd, 0);
        bus_read(4'hC, rd); check(rd == 0, "R3 locked flags", rd, 0);

        // R2 / R4 unlock and divider write, flag duration
        bus_write(4'h0, 32'h5555);
        bus_write(4'h4, 32'd2);
        bus_read(4'h4, rd); check(rd == 2, "R2 div readback", rd, 2);
        bus_read(4'hC, rd); check(rd[0] == 1'b1, "R4 div flag set", rd[0], 1);
        repeat (LAT - 1) @(negedge clk);
        bus_read(4'hC, rd); check(rd[0] == 1'b1, "R4 div flag last", rd[0], 1);
        @(negedge clk);
        bus_read(4'hC, rd); check(rd[0] == 1'b0, "R4 div flag clear", rd[0], 0);

        // R5 write while flag set ignored
        bus_write(4'h8, 32'd7);
        bus_write(4'h8, 32'd9);
        bus_read(4'h8, rd); check(rd == 7, "R5 busy tmo ignored", rd, 7);
        bus_read(4'hC, rd); check(rd[1] == 1'b1, "R4 tmo flag", rd[1], 1);
        repeat (LAT + 2) @(negedge clk);
        bus_read(4'hC, rd); check(rd == 0, "R4 flags clear", rd, 0);

        // R3 relock by other key value
        bus_write(4'h0, 32'h0001_5555);
        bus_write(4'h4, 32'd1);
        bus_read(4'h4, rd); check(rd == 2, "R3 relocked div", rd, 2);

        // R7 no request before start
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wd_rst_o) highs++;
        end
        check(highs == 0, "R7 quiet before start", highs, 0);

        // R7 start with code 0, N=3
        bus_write(4'h0, 32'h5555);
        bus_write(4'h4, 32'd0);
        bus_write(4'h8, 32'd3);
        repeat (LAT + 2) @(negedge clk);
        bus_write(4'h0, 32'hCCCC);
        measure(exp_period(0, 3), "R7 first timeout");

        // R9 cannot be stopped: one request per period window
        bus_write(4'h0, 32'h0000_0000);
        highs = 0;
        for (int i = 0; i < exp_period(0, 3); i++) begin
            @(negedge clk);
            if (wd_rst_o) highs++;
        end
        check(highs == 1, "R9 keeps running", highs, 1);

        // R8 refresh restarts timing
        repeat (5) @(negedge clk);
        bus_write(4'h0, 32'hAAAA);
        measure(exp_period(0, 3), "R8 refresh");

        // R6 code 7 acts like 256
        bus_write(4'h0, 32'h5555);
        bus_write(4'h4, 32'd7);
        bus_write(4'h8, 32'd0);
        bus_read(4'h4, rd); check(rd == 7, "R6 code7 readback", rd, 7);
        repeat (LAT + 2) @(negedge clk);
        bus_write(4'h0, 32'hAAAA);
        measure(exp_period(7, 0), "R6 code7 period");

        // R6/R8 random configurations
        for (int k = 0; k < 8; k++) begin
            int code;
            int n;
            code = $urandom_range(3, 0);
            n = $urandom_range(12, 0);
            bus_write(4'h0, 32'h5555);
            bus_write(4'h4, 32'(code));
            bus_write(4'h8, 32'(n));
            repeat (LAT + 2) @(negedge clk);
            bus_write(4'h0, 32'hAAAA);
            measure(exp_period(code, n), "R6 random period");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule